// File: doc/BRIEF.md
# Oscillator Band Search Controller

This controller chooses one of several oscillator bands for a frequency synthesizer so that the loop's tuning voltage ends up inside a centred window. Software programs a starting band and a settle length, sets the search enable, and pulses start. The controller starts at the programmed band. After each band change it waits a set number of settle ticks, then reads a 3-bit code from the tuning-voltage ADC. It accepts the band or steps one band down or up, depending on the code. It stops when it finds an accepted code or when the search cannot go on.

Two flags report the result. The idle flag is low while a search runs. The found flag tells whether the last search locked. The readback field holds the last code that was evaluated. With the search disabled, the band follows the programmed value directly. Software can then latch the ADC code by hand, but only while conversion is enabled.

Top module: `vbs_band_search`

## Requirements
- R1: While reset is held, search_idle_o=1, search_ok_o=0, band_o=0 and code_rb_o=000. Whenever a search runs, band_o stays within 0..NUM_BANDS-1.
- R2: A start pulse with auto_en_i=1 begins a search at start_band_i, and search_idle_o reads 0 from the next cycle until the search ends. A start pulse with auto_en_i=0 is ignored: search_idle_o stays 1.
- R3: Before each ADC evaluation the controller counts settle_len_i cycles in which tick_i=1, then evaluates in the following cycle. With tick_i held at 1, a search of k evaluations keeps search_idle_o low for exactly k*(settle_len_i+1) cycles. Without ticks the band does not change.
- R4: Codes 010 and 101 are accepted. The search ends with search_ok_o=1 and search_idle_o=1, band_o holds the accepted band, and code_rb_o shows the accepted code.
- R5: Any other code with bit 2 clear (000, 001, 011) moves the band down by one. Any other code with bit 2 set (100, 110, 111) moves it up by one. Each evaluation writes its code to code_rb_o.
- R6: The search ends with search_ok_o=0 and search_idle_o=1 when a step would go below band 0 or above band NUM_BANDS-1. It also ends this way at once, with no evaluation, when start_band_i is above NUM_BANDS-1.
- R7: A search that has made NUM_BANDS evaluations without an accepted code ends with search_ok_o=0, on the band of the last evaluation.
- R8: A start pulse during a running search discards it and restarts from the current start_band_i and settle_len_i.
- R9: While idle with auto_en_i=0, band_o follows start_band_i one cycle later. A cycle with adc_latch_i=1 and adc_en_i=1 copies adc_code_i into code_rb_o. With adc_en_i=0 the latch has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Search start pulse |
| auto_en_i | input | 1 | Search enable (0 = manual band) |
| start_band_i | input | BAND_W | Programmed band: search start or manual band |
| settle_len_i | input | SETTLE_W | Settle ticks counted before each ADC evaluation |
| tick_i | input | 1 | Settle timer tick |
| adc_code_i | input | 3 | Tuning-voltage ADC code |
| adc_en_i | input | 1 | Manual ADC conversion enable |
| adc_latch_i | input | 1 | Manual latch strobe |
| band_o | output | BAND_W | Active oscillator band |
| search_idle_o | output | 1 | 1 when no search is running |
| search_ok_o | output | 1 | 1 when the last search found an accepted code |
| code_rb_o | output | 3 | Latched ADC code readback |

## Verification
The hardest case to reach is the evaluation limit in R7. A monotonic code map always reaches an accepted band or an edge first. The bench therefore builds a code map with no accepted code that pushes the band up below a pivot and down above it, so the band swings between two bands until the limit ends the search. Restarts during settling and stalled ticks are reached by directed sequences. Random code maps, start bands and tick patterns then cover the rest against a bench model of the search.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  localparam int CODE_W = 3;

  typedef enum logic {ST_IDLE, ST_RUN} vbs_state_e;

  // accepted lock codes
  function automatic logic code_is_lock(input logic [CODE_W-1:0] c);
    return (c == 3'b010) || (c == 3'b101);
  endfunction

  // non-lock code with MSB set asks for a higher band
  function automatic logic code_wants_up(input logic [CODE_W-1:0] c);
    return c[CODE_W-1] && !code_is_lock(c);
  endfunction

  function automatic logic code_wants_down(input logic [CODE_W-1:0] c);
    return !c[CODE_W-1] && !code_is_lock(c);
  endfunction
endpackage

// File: rtl/vbs_code_classifier.sv
module vbs_code_classifier
  import vbs_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic              lock_o,
  output logic              up_o,
  output logic              down_o
);
  always_comb begin
    lock_o = code_is_lock(code_i);
    up_o   = code_wants_up(code_i);
    down_o = code_wants_down(code_i);
  end
endmodule

// File: rtl/vbs_settle_timer.sv
module vbs_settle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/vbs_band_search.sv
module vbs_band_search
  import vbs_pkg::*;
#(
  parameter int NUM_BANDS = 24,
  parameter int SETTLE_W  = 8,
  parameter int BAND_W    = $clog2(NUM_BANDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                auto_en_i,
  input  logic [BAND_W-1:0]   start_band_i,
  input  logic [SETTLE_W-1:0] settle_len_i,
  input  logic                tick_i,
  input  logic [2:0]          adc_code_i,
  input  logic                adc_en_i,
  input  logic                adc_latch_i,
  output logic [BAND_W-1:0]   band_o,
  output logic                search_idle_o,
  output logic                search_ok_o,
  output logic [2:0]          code_rb_o
);
  localparam logic [BAND_W-1:0] LAST_BAND = BAND_W'(NUM_BANDS - 1);

  vbs_state_e        state_q;
  logic [BAND_W-1:0] band_q, evals_q;
  logic              ok_q;
  logic [2:0]        rb_q;

  // named internal events
  logic start_ok_w, start_bad_w, run_w, settled_w;
  logic eval_w, lock_w, up_w, down_w, at_edge_w, limit_w, fail_w, adv_w, man_latch_w;

  vbs_code_classifier u_cls (
    .code_i (adc_code_i),
    .lock_o (lock_w),
    .up_o   (up_w),
    .down_o (down_w)
  );

  vbs_settle_timer #(.W(SETTLE_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_ok_w || adv_w),
    .load_val_i (settle_len_i),
    .tick_i     (tick_i),
    .zero_o     (settled_w)
  );

  always_comb begin
    start_ok_w  = start_i && auto_en_i;
    start_bad_w = start_band_i > LAST_BAND;
    run_w       = (state_q == ST_RUN);
    eval_w      = run_w && settled_w && !start_ok_w;
    at_edge_w   = (down_w && band_q == '0) || (up_w && band_q == LAST_BAND);
    limit_w     = (evals_q == LAST_BAND);
    fail_w      = eval_w && !lock_w && (at_edge_w || limit_w);
    adv_w       = eval_w && !lock_w && !fail_w;
    man_latch_w = !run_w && !auto_en_i && adc_en_i && adc_latch_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      band_q  <= '0;
      evals_q <= '0;
      ok_q    <= 1'b0;
      rb_q    <= '0;
    end else if (start_ok_w) begin
      band_q  <= start_band_i;
      evals_q <= '0;
      ok_q    <= 1'b0;
      state_q <= start_bad_w ? ST_IDLE : ST_RUN;
    end else if (eval_w) begin
      rb_q <= adc_code_i;
      if (lock_w) begin
        ok_q    <= 1'b1;
        state_q <= ST_IDLE;
      end else if (fail_w) begin
        state_q <= ST_IDLE;
      end else begin
        band_q  <= up_w ? band_q + BAND_W'(1) : band_q - BAND_W'(1);
        evals_q <= evals_q + BAND_W'(1);
      end
    end else if (!run_w && !auto_en_i) begin
      band_q <= start_band_i;
      if (man_latch_w) rb_q <= adc_code_i;
    end
  end

  assign band_o        = band_q;
  assign search_idle_o = (state_q == ST_IDLE);
  assign search_ok_o   = ok_q;
  assign code_rb_o     = rb_q;

  // R1
  band_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !search_idle_o |-> band_o <= LAST_BAND);

  // R2
  idle_falls_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(search_idle_o) |-> $past(start_i && auto_en_i));

  // R3
  band_held_while_settling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && !settled_w && !start_ok_w) |=> $stable(band_o));

  // R4
  ok_only_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(search_ok_o) |-> search_idle_o);

  // R5
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && eval_w) |=> (band_o == $past(band_o)) ||
                          (band_o == $past(band_o) + BAND_W'(1)) ||
                          (band_o + BAND_W'(1) == $past(band_o)));

  // R9
  readback_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_rb_o) |-> $past(eval_w || man_latch_w));
endmodule

// File: tb/tb_vbs_band_search.sv
module tb_vbs_band_search;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 24;

  logic clk = 0, rst_n = 0;
  logic start = 0, auto_en = 0, tick = 1, adc_en = 0, adc_latch = 0;
  logic [4:0] start_band = 0, band;
  logic [7:0] settle = 0;
  logic [2:0] adc_code, code_rb;
  logic idle, ok;
  logic [2:0] code_map [NB];
  logic [2:0] exp_rb = 0;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vbs_band_search dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .auto_en_i(auto_en),
    .start_band_i(start_band), .settle_len_i(settle), .tick_i(tick),
    .adc_code_i(adc_code), .adc_en_i(adc_en), .adc_latch_i(adc_latch),
    .band_o(band), .search_idle_o(idle), .search_ok_o(ok), .code_rb_o(code_rb)
  );

  always_comb adc_code = (band < 5'(NB)) ? code_map[band] : 3'b000;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_lock(input logic [2:0] c);
    return c == 3'b010 || c == 3'b101;
  endfunction

  // search model from the requirements
  function automatic void model(input int sb, output int f, output int b,
                                output int c, output int k);
    f = 0; b = sb; c = exp_rb; k = 0;
    if (sb > NB - 1) return;
    for (int i = 1; i <= NB; i++) begin
      c = code_map[b]; k = i;
      if (is_lock(c)) begin f = 1; return; end
      if (c[2] == 1'b0 && b == 0) return;
      if (c[2] == 1'b1 && b == NB - 1) return;
      if (i == NB) return;
      b = c[2] ? b + 1 : b - 1;
    end
  endfunction

  task automatic wait_idle(input bit rand_tick, output int low);
    low = 0;
    while (!idle && low < 5000) begin
      low++;
      if (rand_tick) tick = 1'($urandom % 2);
      @(negedge clk);
    end
    tick = 1;
    if (low >= 5000) check("R2 search never ended", 0, 1);
  endtask

  task automatic do_search(input int sb, input int st, input bit rand_tick,
                           input bit timed, input string tag);
    int f, b, c, k, low;
    model(sb, f, b, c, k);
    @(negedge clk);
    start_band = 5'(sb); settle = 8'(st); auto_en = 1; start = 1; tick = 1;
    @(negedge clk);
    start = 0;
    wait_idle(rand_tick, low);
    check({tag, " R4/R6 found flag"}, int'(ok), f);
    check({tag, " R5 final band"}, int'(band), b);
    check({tag, " R5 readback code"}, int'(code_rb), c);
    if (timed) check({tag, " R3 busy cycles"}, low, k * (st + 1));
    exp_rb = 3'(c);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < NB; i++) code_map[i] = 3'b111;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 idle in reset", int'(idle), 1);
    check("R1 ok in reset", int'(ok), 0);
    check("R1 band in reset", int'(band), 0);
    check("R1 readback in reset", int'(code_rb), 0);
    rst_n = 1;

    // R2 start ignored when disabled; R9 band follows programmed value
    start_band = 9; start = 1;
    @(negedge clk); start = 0;
    check("R2 start ignored idle", int'(idle), 1);
    check("R9 manual band", int'(band), 9);

    // R9 manual latch gated by conversion enable
    start_band = 7; code_map[7] = 3'b011;
    @(negedge clk);
    adc_en = 1; adc_latch = 1;
    @(negedge clk); adc_latch = 0;
    check("R9 manual latch", int'(code_rb), 3);
    code_map[7] = 3'b110; adc_en = 0; adc_latch = 1;
    @(negedge clk); adc_latch = 0;
    check("R9 latch without enable", int'(code_rb), 3);
    exp_rb = 3'b011;

    // R4/R5 upward walk to lock, timed
    for (int i = 0; i < NB; i++) code_map[i] = 3'b110;
    code_map[10] = 3'b010;
    do_search(5, 2, 0, 1, "up");
    // downward walk with 011 and 001
    for (int i = 0; i < NB; i++) code_map[i] = (i % 2) ? 3'b001 : 3'b011;
    code_map[3] = 3'b101;
    do_search(15, 0, 0, 1, "down");
    // R6 low and high edge
    for (int i = 0; i < NB; i++) code_map[i] = 3'b000;
    do_search(3, 1, 0, 1, "R6 low edge");
    for (int i = 0; i < NB; i++) code_map[i] = 3'b100;
    do_search(20, 1, 0, 1, "R6 high edge");
    // R6 out-of-range start: no busy period
    do_search(26, 1, 0, 1, "R6 bad start");
    // R7 oscillation with no lock hits evaluation limit
    for (int i = 0; i < NB; i++) code_map[i] = (i < 12) ? 3'b111 : 3'b000;
    do_search(8, 1, 0, 1, "R7 limit");

    // R3 no ticks means no progress
    for (int i = 0; i < NB; i++) code_map[i] = 3'b111;
    code_map[6] = 3'b010;
    @(negedge clk);
    start_band = 4; settle = 3; auto_en = 1; start = 1; tick = 0;
    @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    check("R3 stalled busy", int'(idle), 0);
    check("R3 stalled band", int'(band), 4);
    begin
      int low;
      tick = 1;
      wait_idle(0, low);
    end
    check("R3 after stall band", int'(band), 6);
    check("R3 after stall ok", int'(ok), 1);
    exp_rb = 3'b010;

    // R8 restart during settling
    code_map[14] = 3'b101;
    @(negedge clk);
    start_band = 2; settle = 10; start = 1;
    @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    check("R8 first search running", int'(idle), 0);
    start_band = 12; settle = 1; start = 1;
    @(negedge clk); start = 0;
    begin
      int low;
      wait_idle(0, low);
      check("R8 restart busy cycles", low, 3 * 2);
    end
    check("R8 restart band", int'(band), 14);
    check("R8 restart ok", int'(ok), 1);
    check("R8 restart code", int'(code_rb), 5);
    exp_rb = 3'b101;

    // random maps, starts, settle lengths and tick patterns
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < NB; i++) code_map[i] = 3'($urandom % 8);
      do_search(int'($urandom % 25), int'($urandom % 4), n[0], 0, "rand R4");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule